// File: doc/BRIEF.md
# Sixty-Four Source Interrupt Controller

This block gathers up to 63 interrupt request lines, numbered 1 to 63, into one request line to the processor. Each raw line goes through a two-flop synchronizer. It is then classified as one of three kinds: a plain active-low level input, an external pin with a choice of level or falling-edge sensing, or a port pin with a choice of both-edge or falling-edge sensing. A detected event sets a pending latch. Software clears a pending latch by writing a 1 to it.

Pending and enable state are spread across two 32-bit words, called the high word and the low word, using a fixed non-linear map from source number to bit. Among the sources that are both pending and enabled, the one with the lowest number wins. Its number appears in the top six bits of a read-only vector register. The processor line is high whenever that vector is nonzero. The register port is a plain 32-bit read/write strobe interface with byte addresses. Reads return data in the same cycle as the read strobe.

Top module: `intc64`

## Requirements
- R1: After reset, both enable words, both pending words and the sense word read 0, the vector reads 0 and `irq_out` is low.
- R2: Source map (H = high word, L = low word). Sources 1..15 use L bit 16−s. Sources 16..31 use H bit 31−s. Sources 32..47 use L bit 63−s. Sources 48..63 use H bit s−32. L bit 0 always reads 0.
- R3: An enable bit of 1 lets its source reach the vector, and enable words read back as written. A pending bit is still captured while its source is disabled, but it has no effect on the vector or on `irq_out`.
- R4: Writing a pending word clears exactly the bits written as 1. An edge-type source that has been cleared stays clear until its next qualifying edge.
- R5: Sources outside 19..25 and 48..63 are active-low level inputs with no sense control. Such a source sets its pending bit on every clock while its input is low, so a clear has no lasting effect until the input goes high.
- R6: External pins 19..25 take their sense bit from sense-word bit 33−s. A value of 0 selects active-low level sensing and a value of 1 selects falling-edge sensing.
- R7: Port pins 48..63 take their sense bit from sense-word bit s−32. A value of 0 selects both-edge sensing and a value of 1 selects falling-edge sensing.
- R8: Vector bits 31:26 hold the lowest source number that is both pending and enabled, or 0 if there is none. Bits 25:0 read 0.
- R9: `irq_out` is high exactly when the vector is nonzero.
- R10: Input line 0 is ignored. It never sets a pending bit and never shows in the vector.
- R11: Register byte addresses are 0x00 enable-high, 0x04 enable-low, 0x08 pending-high, 0x0C pending-low, 0x10 sense and 0x14 vector (read only). An input change reaches pending on the third rising clock edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte address; accesses with bits 1:0 nonzero are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high, 0 otherwise |
| src_in | input | 64 | Raw interrupt lines, idle high |
| irq_out | output | 1 | Request to the processor |

## Verification
Each plain and external source is driven low one at a time. This single-source sweep shows the map to its word and bit and the vector number for every source, and shows that a clear cannot hold while a level input stays low. The port pins are swept with both sense settings, using rising and falling edges, which separates both-edge sensing from falling-only sensing. The external pins are held low under falling-edge sense to separate that mode from level sensing. Several sources are then made pending together, with enables toggled, to show the lowest-number priority, the effect of disabling a source, and capture of a disabled source.

// File: rtl/intc64_pkg.sv
package intc64_pkg;
  localparam int NUM_SRC = 64;
  localparam int WORD_W = 32;
  localparam int VEC_W = $clog2(NUM_SRC);

  typedef enum logic [1:0] {KIND_PLAIN, KIND_EXT, KIND_PORT} srcKind_t;
  typedef enum logic [2:0] {RD_NONE, RD_MASKHI, RD_MASKLO, RD_PENDHI, RD_PENDLO, RD_SENSE, RD_VEC} rdSel_t;

  typedef struct packed {
    logic wrMaskHi;
    logic wrMaskLo;
    logic clrPendHi;
    logic clrPendLo;
    logic wrSense;
    rdSel_t rdSel;
  } busStrobe_t;

  // true when a source lives in the high word
  function automatic bit srcInHigh(int s);
    return (s >= 16 && s <= 31) || (s >= 48);
  endfunction

  function automatic int srcBitPos(int s);
    if (s == 0) return 0;
    else if (s < 16) return 16 - s;
    else if (s < 32) return 31 - s;
    else if (s < 48) return 63 - s;
    else return s - 32;
  endfunction

  function automatic srcKind_t srcKind(int s);
    if (s >= 19 && s <= 25) return KIND_EXT;
    else if (s >= 48) return KIND_PORT;
    else return KIND_PLAIN;
  endfunction

  function automatic int senseBitPos(int s);
    return (s >= 48) ? s - 32 : 33 - s;
  endfunction
endpackage

// File: rtl/intc64_ctrl.sv
module intc64_ctrl
  import intc64_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              busRd,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output busStrobe_t        strb
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] wordIdx;
  logic aligned;

  assign wordIdx = busAddr[ADDR_W-1:2];
  assign aligned = (busAddr[1:0] == 2'b00);

  always_comb begin
    strb = '0;
    strb.rdSel = RD_NONE;
    if (aligned) begin
      case (int'(wordIdx))
        0: begin strb.wrMaskHi  = busWr; if (busRd) strb.rdSel = RD_MASKHI; end
        1: begin strb.wrMaskLo  = busWr; if (busRd) strb.rdSel = RD_MASKLO; end
        2: begin strb.clrPendHi = busWr; if (busRd) strb.rdSel = RD_PENDHI; end
        3: begin strb.clrPendLo = busWr; if (busRd) strb.rdSel = RD_PENDLO; end
        4: begin strb.wrSense   = busWr; if (busRd) strb.rdSel = RD_SENSE;  end
        5: begin if (busRd) strb.rdSel = RD_VEC; end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/intc64_dp.sv
module intc64_dp
  import intc64_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  busStrobe_t         strb,
  input  logic [WORD_W-1:0]  wdata,
  input  logic [NUM_SRC-1:0] srcIn,
  output logic [WORD_W-1:0]  rdata,
  output logic [VEC_W-1:0]   vecNum
);
  logic [NUM_SRC-1:0] syncQ [SYNC_STAGES];
  logic [NUM_SRC-1:0] srcNow, prevQ, pendQ;
  logic [NUM_SRC-1:0] srcMask, srcClr, srcEvt, eligible;
  logic [WORD_W-1:0]  maskHi, maskLo, senseQ, pendHiWord, pendLoWord;

  // input synchronizer, idle level is high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) syncQ[i] <= '1;
      prevQ <= '1;
    end else begin
      syncQ[0] <= srcIn;
      for (int i = 1; i < SYNC_STAGES; i++) syncQ[i] <= syncQ[i-1];
      prevQ <= srcNow;
    end
  end
  assign srcNow = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      maskHi <= '0;
      maskLo <= '0;
      senseQ <= '0;
    end else begin
      if (strb.wrMaskHi) maskHi <= wdata;
      if (strb.wrMaskLo) maskLo <= wdata;
      if (strb.wrSense)  senseQ <= wdata;
    end
  end

  assign srcMask[0] = 1'b0;
  assign srcClr[0] = 1'b0;
  assign srcEvt[0] = 1'b0;
  assign pendLoWord[0] = 1'b0;

  for (genvar s = 1; s < NUM_SRC; s++) begin : g_src
    localparam bit HI = srcInHigh(s);
    localparam int BP = srcBitPos(s);
    localparam srcKind_t KIND = srcKind(s);

    if (HI) begin : g_hi
      assign srcMask[s] = maskHi[BP];
      assign srcClr[s] = strb.clrPendHi & wdata[BP];
      assign pendHiWord[BP] = pendQ[s];
    end else begin : g_lo
      assign srcMask[s] = maskLo[BP];
      assign srcClr[s] = strb.clrPendLo & wdata[BP];
      assign pendLoWord[BP] = pendQ[s];
    end

    if (KIND == KIND_PLAIN) begin : g_plain
      assign srcEvt[s] = ~srcNow[s];
    end else begin : g_sel
      localparam int SB = senseBitPos(s);
      logic fallEdge;
      assign fallEdge = prevQ[s] & ~srcNow[s];
      if (KIND == KIND_EXT) begin : g_ext
        assign srcEvt[s] = senseQ[SB] ? fallEdge : ~srcNow[s];
      end else begin : g_port
        assign srcEvt[s] = senseQ[SB] ? fallEdge : (prevQ[s] ^ srcNow[s]);
      end
    end
  end

  // a new event wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pendQ <= '0;
    else        pendQ <= (pendQ & ~srcClr) | srcEvt;
  end

  assign eligible = pendQ & srcMask;

  always_comb begin
    vecNum = '0;
    for (int s = NUM_SRC - 1; s > 0; s--)
      if (eligible[s]) vecNum = VEC_W'(s);
  end

  always_comb begin
    case (strb.rdSel)
      RD_MASKHI: rdata = maskHi;
      RD_MASKLO: rdata = maskLo;
      RD_PENDHI: rdata = pendHiWord;
      RD_PENDLO: rdata = pendLoWord;
      RD_SENSE:  rdata = senseQ;
      RD_VEC:    rdata = {vecNum, {(WORD_W - VEC_W){1'b0}}};
      default:   rdata = '0;
    endcase
  end

  // R8
  vec_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vecNum != '0) |-> eligible[vecNum]);
  // R8
  vec_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eligible & ((64'd1 << vecNum) - 64'd1)) == '0);
  // R8
  vec_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vecNum == '0) |-> (eligible == '0));
  // R10
  src0_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pendQ[0]);
  // R3
  mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.wrMaskHi |=> (maskHi == $past(wdata)));
endmodule

// File: rtl/intc64.sv
module intc64
  import intc64_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [63:0]       src_in,
  output logic              irq_out
);
  busStrobe_t strb;
  logic [VEC_W-1:0] vecNum;

  intc64_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .busRd(bus_rd), .busWr(bus_wr), .busAddr(bus_addr), .strb(strb)
  );

  intc64_dp #(.SYNC_STAGES(SYNC_STAGES)) i_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .wdata(bus_wdata),
    .srcIn(src_in), .rdata(bus_rdata), .vecNum(vecNum)
  );

  assign irq_out = (vecNum != '0);

  // R9
  irq_vec_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.rdSel == RD_VEC) |-> (irq_out == (bus_rdata[31:26] != 6'd0)));
endmodule

// File: tb/test_intc64.sv
module test_intc64;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [63:0] src_in = '1;
  logic irq_out;
  int nChecks = 0, nFails = 0;

  localparam logic [7:0] A_MH = 8'h00, A_ML = 8'h04, A_PH = 8'h08, A_PL = 8'h0C, A_SN = 8'h10, A_VEC = 8'h14;

  always #10 clk = ~clk;

  intc64 i_intc64 (.*);

  function automatic bit isHigh(int s);
    return (s >= 16 && s <= 31) || s >= 48;
  endfunction
  function automatic int bitOf(int s);
    if (s < 16) return 16 - s;
    if (s < 32) return 31 - s;
    if (s < 48) return 63 - s;
    return s - 32;
  endfunction
  function automatic logic [7:0] pendAddr(int s);
    return isHigh(s) ? A_PH : A_PL;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic busRead(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    busRead(A_MH, d); check("R1 maskHi", d, 0);
    busRead(A_ML, d); check("R1 maskLo", d, 0);
    busRead(A_PH, d); check("R1 pendHi", d, 0);
    busRead(A_PL, d); check("R1 pendLo", d, 0);
    busRead(A_SN, d); check("R1 sense", d, 0);
    busRead(A_VEC, d); check("R1 vector", d, 0);
    check("R1 irq", {31'd0, irq_out}, 0);

    // R3 R11 readback
    busWrite(A_MH, 32'hFFFFFFFF);
    busWrite(A_ML, 32'hFFFFFFFF);
    busRead(A_MH, d); check("R3 maskHi readback", d, 32'hFFFFFFFF);
    busRead(A_ML, d); check("R3 maskLo readback", d, 32'hFFFFFFFF);

    // R5 R6 R2 R8 level sweep, sense all 0
    for (int s = 1; s < 48; s++) begin
      string tag;
      tag = (s >= 19 && s <= 25) ? "R6 ext level" : "R5 level";
      src_in[s] = 1'b0;
      settle();
      busRead(A_VEC, d); check({tag, " R8 vector"}, d, 32'(s) << 26);
      check("R9 irq high", {31'd0, irq_out}, 1);
      busRead(pendAddr(s), d); check({tag, " R2 map"}, d, 32'd1 << bitOf(s));
      busWrite(pendAddr(s), 32'd1 << bitOf(s));
      busRead(pendAddr(s), d); check({tag, " clear while low"}, d, 32'd1 << bitOf(s));
      src_in[s] = 1'b1;
      settle();
      busWrite(pendAddr(s), 32'd1 << bitOf(s));
      busRead(pendAddr(s), d); check("R4 cleared", d, 0);
      check("R9 irq low", {31'd0, irq_out}, 0);
    end

    // R7 port pins, both-edge mode
    for (int s = 48; s < 64; s++) begin
      src_in[s] = 1'b0; settle();
      busRead(A_PH, d); check("R7 both fall R2", d, 32'd1 << (s - 32));
      busRead(A_VEC, d); check("R7 R8 vector", d, 32'(s) << 26);
      busWrite(A_PH, 32'd1 << (s - 32)); settle();
      busRead(A_PH, d); check("R4 edge stays clear", d, 0);
      src_in[s] = 1'b1; settle();
      busRead(A_PH, d); check("R7 both rise", d, 32'd1 << (s - 32));
      busWrite(A_PH, 32'd1 << (s - 32));
    end

    // R6 R7 falling-edge mode
    busWrite(A_SN, 32'hFFFF7F00);
    for (int s = 48; s < 64; s++) begin
      src_in[s] = 1'b0; settle();
      busRead(A_PH, d); check("R7 fall-only fall", d, 32'd1 << (s - 32));
      busWrite(A_PH, 32'd1 << (s - 32));
      src_in[s] = 1'b1; settle();
      busRead(A_PH, d); check("R7 fall-only rise ignored", d, 0);
    end
    for (int s = 19; s <= 25; s++) begin
      src_in[s] = 1'b0; settle();
      busRead(A_PH, d); check("R6 fall edge", d, 32'd1 << (31 - s));
      busWrite(A_PH, 32'd1 << (31 - s)); settle();
      busRead(A_PH, d); check("R6 held low no reassert", d, 0);
      src_in[s] = 1'b1; settle();
    end

    // R3 masked capture
    busWrite(A_MH, 32'h0); busWrite(A_ML, 32'h0);
    src_in[50] = 1'b0; settle();
    busRead(A_PH, d); check("R3 captured while masked", d, 32'd1 << 18);
    busRead(A_VEC, d); check("R3 masked vector", d, 0);
    check("R3 masked irq", {31'd0, irq_out}, 0);
    busWrite(A_MH, 32'd1 << 18);
    busRead(A_VEC, d); check("R3 unmasked vector", d, 32'd50 << 26);
    check("R9 irq", {31'd0, irq_out}, 1);

    // R8 priority
    busWrite(A_MH, 32'hFFFFFFFF); busWrite(A_ML, 32'hFFFFFFFF);
    src_in[60] = 1'b0; src_in[55] = 1'b0; settle();
    busRead(A_VEC, d); check("R8 lowest of 50/55/60", d, 32'd50 << 26);
    busWrite(A_PH, 32'd1 << 18);
    busRead(A_VEC, d); check("R8 next 55", d, 32'd55 << 26);
    busWrite(A_MH, ~(32'd1 << 23));
    busRead(A_VEC, d); check("R8 R3 55 masked -> 60", d, 32'd60 << 26);
    src_in[5] = 1'b0; settle();
    busRead(A_VEC, d); check("R8 level 5 wins", d, 32'd5 << 26);
    src_in[5] = 1'b1; settle();
    busWrite(A_PL, 32'd1 << 11);
    busRead(A_VEC, d); check("R8 back to 60", d, 32'd60 << 26);

    // R10 line 0 ignored
    busWrite(A_PH, 32'hFFFFFFFF);
    src_in[0] = 1'b0; settle();
    busRead(A_PL, d); check("R10 pendLo", d, 0);
    busRead(A_VEC, d); check("R10 vector", d, 0);
    check("R10 irq", {31'd0, irq_out}, 0);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule